// File: doc/BRIEF.md
# Floating-Point Register Rename Status Table

This block holds the architectural floating-point register file of a dynamically scheduled core. Each register has a status field naming the reservation station that is due to write it. A status of zero means the stored value is current. When an operation issues, two read ports look up its source registers. Each port returns either a usable value or the tag of the station that will produce it. In the same cycle a destination-claim port records the issuing station as the new producer of the destination register.

Finished operations drive a result bus with a station tag and a value. A register takes the value only if its status still names that station. The value is then stored and the status is cleared. A register that has since been claimed by a younger producer ignores the older result. This tag-gated writeback keeps stale producers from overwriting newer results, which removes write-after-write and write-after-read hazards.

Each register runs a two-state machine:

| State | Meaning |
|---|---|
| `ENT_READY` | The value is present and the tag is zero. |
| `ENT_PENDING` | A station tag is held. |

Its transitions are:

| From | Event | To | Effect |
|---|---|---|---|
| `ENT_READY` | claim | `ENT_PENDING` | Tag loaded. |
| `ENT_PENDING` | claim | `ENT_PENDING` | Tag retargeted to the new station. |
| `ENT_PENDING` | matching broadcast, no claim in the same cycle | `ENT_READY` | Value written, tag cleared. |
| either | anything else | same state | Hold. |

Top module: `fp_rename_table`

## Requirements
- R1: After reset, every register reads with tag 0 and value 0.
- R2: A claim with a nonzero tag makes the register read, from the next cycle on, with that tag and value 0. A claim whose tag is 0 has no effect.
- R3: A read of a register whose status is zero returns its stored value with tag 0.
- R4: A broadcast whose tag equals a register's status stores the broadcast value in that register and clears its status from the next cycle on.
- R5: A broadcast of a tag that a register no longer holds, because a later claim replaced it, leaves that register pending on the newer tag with its value unwritten.
- R6: A broadcast whose tag matches no register status changes no register.
- R7: A claim and a broadcast that matches the same register's old tag in the same cycle leave the register pending on the claimed tag, and the broadcast value is not stored.
- R8: A read of a pending register in the cycle its producer broadcasts returns the broadcast value with tag 0.
- R9: Reads in the same cycle as a claim return the register state from before that claim.
- R10: A broadcast carrying tag 0 updates no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_idx | input | IDX_W | Source register index, read port A |
| src_a_value | output | DATA_W | Port A value; zero while tag is nonzero |
| src_a_tag | output | TAG_W | Port A producer tag; zero means value valid |
| src_b_idx | input | IDX_W | Source register index, read port B |
| src_b_value | output | DATA_W | Port B value; zero while tag is nonzero |
| src_b_tag | output | TAG_W | Port B producer tag; zero means value valid |
| claim_valid | input | 1 | Destination claim request |
| claim_idx | input | IDX_W | Destination register index |
| claim_tag | input | TAG_W | Issuing station identifier (nonzero) |
| bcast_valid | input | 1 | Result bus valid |
| bcast_tag | input | TAG_W | Station producing the result |
| bcast_value | input | DATA_W | Result value |

## Verification
The assertions assume that a station identifier is never claimed while an earlier instruction on that station is still waiting to broadcast. Under that assumption at most one register status matches a broadcast tag in any cycle. The stimulus enforces this by tracking which stations are busy. Claims draw only from free stations, and a station is freed only when its result is broadcast. Most broadcasts name busy stations. Some deliberately name a free station or tag zero, and these are only ever idle matches, never duplicate ones.

// File: rtl/fprt_pkg.sv
package fprt_pkg;
    typedef enum logic {
        ENT_READY   = 1'b0,
        ENT_PENDING = 1'b1
    } ent_state_e;
endpackage

// File: rtl/fprt_entry.sv
module fprt_entry
    import fprt_pkg::*;
#(
    parameter int DW = 64,
    parameter int TW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          claim_hit,
    input  logic [TW-1:0] claim_tag,
    input  logic          bc_valid,
    input  logic [TW-1:0] bc_tag,
    input  logic [DW-1:0] bc_value,
    output logic [DW-1:0] value_o,
    output logic [TW-1:0] tag_o,
    output logic          bc_hit_o
);

    ent_state_e    state_q, state_d;
    logic [TW-1:0] tag_q, tag_d;
    logic [DW-1:0] value_q, value_d;
    logic          bc_hit;

    assign bc_hit = bc_valid && (state_q == ENT_PENDING) && (tag_q == bc_tag);

    // next-state process
    always_comb begin
        state_d = state_q;
        tag_d   = tag_q;
        value_d = value_q;
        unique case (state_q)
            ENT_READY: begin
                if (claim_hit) begin
                    state_d = ENT_PENDING;
                    tag_d   = claim_tag;
                end
            end
            ENT_PENDING: begin
                if (claim_hit) begin
                    tag_d = claim_tag;
                end else if (bc_hit) begin
                    state_d = ENT_READY;
                    tag_d   = '0;
                    value_d = bc_value;
                end
            end
            default: begin
                state_d = ENT_READY;
                tag_d   = '0;
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_READY;
            tag_q   <= '0;
            value_q <= '0;
        end else begin
            state_q <= state_d;
            tag_q   <= tag_d;
            value_q <= value_d;
        end
    end

    // output process
    always_comb begin
        value_o  = value_q;
        tag_o    = (state_q == ENT_PENDING) ? tag_q : '0;
        bc_hit_o = bc_hit;
    end

    AST_READY_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_READY) |-> (tag_q == '0)); // R1

    AST_CLAIM_SETS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        claim_hit |=> (state_q == ENT_PENDING && tag_q == $past(claim_tag))); // R2

    AST_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_hit && !claim_hit) |=> (state_q == ENT_READY && value_q == $past(bc_value))); // R4

    AST_CLAIM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_hit && claim_hit) |=> $stable(value_q)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!bc_hit && !claim_hit) |=> ($stable(value_q) && $stable(tag_q))); // R6

endmodule

// File: rtl/fprt_read_port.sv
module fprt_read_port #(
    parameter int NREG = 32,
    parameter int DW   = 64,
    parameter int TW   = 3,
    parameter int IW   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [IW-1:0]            idx,
    input  logic [NREG-1:0][DW-1:0]  values,
    input  logic [NREG-1:0][TW-1:0]  tags,
    input  logic                     bc_valid,
    input  logic [TW-1:0]            bc_tag,
    input  logic [DW-1:0]            bc_value,
    output logic [DW-1:0]            value_o,
    output logic [TW-1:0]            tag_o
);

    logic [TW-1:0] sel_tag;
    logic [DW-1:0] sel_value;

    always_comb begin
        sel_tag   = tags[idx];
        sel_value = values[idx];
        if (sel_tag == '0) begin
            value_o = sel_value;
            tag_o   = '0;
        end else if (bc_valid && bc_tag == sel_tag) begin
            value_o = bc_value;
            tag_o   = '0;
        end else begin
            value_o = '0;
            tag_o   = sel_tag;
        end
    end

    AST_PEND_NO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_o != '0) |-> (value_o == '0)); // R2

    AST_FWD_NOT_STALE: assert property (@(posedge clk) disable iff (!rst_n)
        (bc_valid && tag_o != '0) |-> (tag_o != bc_tag)); // R8

endmodule

// File: rtl/fp_rename_table.sv
module fp_rename_table #(
    parameter int NUM_REGS     = 32,
    parameter int DATA_W       = 64,
    parameter int NUM_STATIONS = 7,
    parameter int IDX_W        = $clog2(NUM_REGS),
    parameter int TAG_W        = $clog2(NUM_STATIONS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  src_a_idx,
    output logic [DATA_W-1:0] src_a_value,
    output logic [TAG_W-1:0]  src_a_tag,
    input  logic [IDX_W-1:0]  src_b_idx,
    output logic [DATA_W-1:0] src_b_value,
    output logic [TAG_W-1:0]  src_b_tag,
    input  logic              claim_valid,
    input  logic [IDX_W-1:0]  claim_idx,
    input  logic [TAG_W-1:0]  claim_tag,
    input  logic              bcast_valid,
    input  logic [TAG_W-1:0]  bcast_tag,
    input  logic [DATA_W-1:0] bcast_value
);

    localparam int NUM_RD = 2;

    logic [NUM_REGS-1:0][DATA_W-1:0] ent_value;
    logic [NUM_REGS-1:0][TAG_W-1:0]  ent_tag;
    logic [NUM_REGS-1:0]             ent_bc_hit;
    logic                            claim_eff;

    logic [NUM_RD-1:0][IDX_W-1:0]    rd_idx;
    logic [NUM_RD-1:0][DATA_W-1:0]   rd_value;
    logic [NUM_RD-1:0][TAG_W-1:0]    rd_tag;

    assign claim_eff = claim_valid && (claim_tag != '0);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_ent
        logic hit;
        assign hit = claim_eff && (claim_idx == IDX_W'(gi));
        fprt_entry #(.DW(DATA_W), .TW(TAG_W)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .claim_hit (hit),
            .claim_tag (claim_tag),
            .bc_valid  (bcast_valid),
            .bc_tag    (bcast_tag),
            .bc_value  (bcast_value),
            .value_o   (ent_value[gi]),
            .tag_o     (ent_tag[gi]),
            .bc_hit_o  (ent_bc_hit[gi])
        );
    end

    assign rd_idx[0] = src_a_idx;
    assign rd_idx[1] = src_b_idx;

    for (genvar gr = 0; gr < NUM_RD; gr++) begin : g_rd
        fprt_read_port #(
            .NREG(NUM_REGS), .DW(DATA_W), .TW(TAG_W), .IW(IDX_W)
        ) u_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (rd_idx[gr]),
            .values   (ent_value),
            .tags     (ent_tag),
            .bc_valid (bcast_valid),
            .bc_tag   (bcast_tag),
            .bc_value (bcast_value),
            .value_o  (rd_value[gr]),
            .tag_o    (rd_tag[gr])
        );
    end

    assign src_a_value = rd_value[0];
    assign src_a_tag   = rd_tag[0];
    assign src_b_value = rd_value[1];
    assign src_b_tag   = rd_tag[1];

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ent_bc_hit) <= 1); // R4

    AST_ZERO_TAG_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bcast_valid && bcast_tag == '0) |-> (ent_bc_hit == '0)); // R10

endmodule

// File: tb/fp_rename_table_tb.sv
`timescale 1ns/1ps
module fp_rename_table_tb_top;
    localparam int NREG = 32;
    localparam int DW   = 64;
    localparam int NST  = 7;
    localparam int TW   = 3;
    localparam int IW   = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [IW-1:0] a_idx, b_idx, c_idx;
    logic [DW-1:0] a_val, b_val, bc_val;
    logic [TW-1:0] a_tag, b_tag, c_tag, bc_tag;
    logic          c_vld, bc_vld;

    always #2.5 clk = ~clk;

    fp_rename_table dut_i (
        .clk(clk), .rst_n(rst_n),
        .src_a_idx(a_idx), .src_a_value(a_val), .src_a_tag(a_tag),
        .src_b_idx(b_idx), .src_b_value(b_val), .src_b_tag(b_tag),
        .claim_valid(c_vld), .claim_idx(c_idx), .claim_tag(c_tag),
        .bcast_valid(bc_vld), .bcast_tag(bc_tag), .bcast_value(bc_val)
    );

    logic [DW-1:0] m_val [NREG];
    logic [TW-1:0] m_tag [NREG];
    bit            busy  [NST+1];
    int nvec = 0, nerr = 0;
    bit done = 0;

    task automatic chk(string req, logic [DW-1:0] av, logic [TW-1:0] at,
                       logic [DW-1:0] ev, logic [TW-1:0] et);
        nvec++;
        if (av !== ev || at !== et) begin
            nerr++;
            $display("FAIL %s: got value=%h tag=%0d, expected value=%h tag=%0d",
                     req, av, at, ev, et);
        end
    endtask

    function automatic string exp_read(int idx, output logic [DW-1:0] v,
                                       output logic [TW-1:0] t);
        if (m_tag[idx] == 0) begin
            v = m_val[idx]; t = 0; return "R3";
        end else if (bc_vld && bc_tag == m_tag[idx]) begin
            v = bc_val; t = 0; return "R8";
        end
        v = 0; t = m_tag[idx]; return "R2";
    endfunction

    task automatic drive(int ai, int bi, bit cv, int ci, int ct,
                         bit bv, int bt, logic [DW-1:0] bval);
        a_idx = IW'(ai); b_idx = IW'(bi);
        c_vld = cv; c_idx = IW'(ci); c_tag = TW'(ct);
        bc_vld = bv; bc_tag = TW'(bt); bc_val = bval;
    endtask

    // Check both read ports mid-cycle, then update the model at the edge.
    task automatic step(string lbl);
        logic [DW-1:0] ev; logic [TW-1:0] et; string r;
        #1;
        r = exp_read(int'(a_idx), ev, et);
        chk(lbl == "" ? r : lbl, a_val, a_tag, ev, et);
        r = exp_read(int'(b_idx), ev, et);
        chk(lbl == "" ? r : lbl, b_val, b_tag, ev, et);
        @(posedge clk);
        for (int i = 0; i < NREG; i++) begin
            if (c_vld && c_tag != 0 && int'(c_idx) == i) m_tag[i] = c_tag;
            else if (bc_vld && m_tag[i] != 0 && m_tag[i] == bc_tag) begin
                m_val[i] = bc_val; m_tag[i] = 0;
            end
        end
        if (bc_vld && bc_tag != 0) busy[bc_tag] = 0;
        if (c_vld && c_tag != 0) busy[c_tag] = 1;
        @(negedge clk);
    endtask

    function automatic logic [DW-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        nerr++;
        $display("FAIL watchdog: got timeout, expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NREG; i++) begin m_val[i] = 0; m_tag[i] = 0; end
        for (int s = 0; s <= NST; s++) busy[s] = 0;
        rst_n = 0;
        drive(0, 0, 0, 0, 0, 0, 0, '0);
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        drive(0, 31, 0, 0, 0, 0, 0, '0); step("R1");
        // R2: claim reg5 with station 3
        drive(1, 2, 1, 5, 3, 0, 0, '0); step("");
        drive(5, 5, 0, 0, 0, 0, 0, '0); step("R2");
        // R9: claim reg7 while both ports read it
        drive(7, 7, 1, 7, 2, 0, 0, '0); step("R9");
        drive(7, 5, 0, 0, 0, 0, 0, '0); step("R2");
        // R4: station 3 broadcasts
        drive(9, 9, 0, 0, 0, 1, 3, 64'h1111_2222_3333_4444); step("");
        drive(5, 5, 0, 0, 0, 0, 0, '0); step("R4");
        // R8: read during matching broadcast
        drive(7, 7, 0, 0, 0, 1, 2, 64'hABCD_0000_1234_5678); step("R8");
        drive(7, 7, 0, 0, 0, 0, 0, '0); step("R4");
        // R5: reclaim, then stale producer broadcasts
        drive(0, 0, 1, 10, 1, 0, 0, '0); step("");
        drive(0, 0, 1, 10, 4, 0, 0, '0); step("");
        drive(0, 0, 0, 0, 0, 1, 1, 64'hDEAD_BEEF_0000_0001); step("");
        drive(10, 10, 0, 0, 0, 0, 0, '0); step("R5");
        drive(3, 3, 0, 0, 0, 1, 4, 64'h0F0F_0F0F_0F0F_0F0F); step("");
        drive(10, 10, 0, 0, 0, 0, 0, '0); step("R5");
        // R7: claim and matching broadcast in the same cycle
        drive(0, 0, 1, 12, 5, 0, 0, '0); step("");
        drive(0, 0, 1, 12, 6, 1, 5, 64'h5555_5555_5555_5555); step("");
        drive(12, 12, 0, 0, 0, 0, 0, '0); step("R7");
        drive(0, 0, 0, 0, 0, 1, 6, 64'h7777_0000_7777_0000); step("");
        drive(12, 12, 0, 0, 0, 0, 0, '0); step("R7");
        // R10: broadcast with tag zero; claim with tag zero ignored (R2)
        drive(0, 0, 0, 0, 0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF); step("");
        drive(5, 31, 0, 0, 0, 0, 0, '0); step("R10");
        drive(0, 0, 1, 5, 0, 0, 0, '0); step("");
        drive(5, 5, 0, 0, 0, 0, 0, '0); step("R2");
        // R6: broadcast of a free station
        drive(0, 0, 0, 0, 0, 1, 7, 64'h9999_9999_9999_9999); step("");
        drive(7, 12, 0, 0, 0, 0, 0, '0); step("R6");

        // constrained random traffic
        for (int n = 0; n < 3000; n++) begin
            int ct, bt, k; bit cv, bv;
            cv = 0; ct = 0; bv = 0; bt = 0;
            if ($urandom_range(1, 0) == 1) begin
                k = $urandom_range(NST, 1);
                for (int j = 0; j < NST; j++) begin
                    int s; s = ((k - 1 + j) % NST) + 1;
                    if (!cv && !busy[s]) begin cv = 1; ct = s; end
                end
            end
            if ($urandom_range(9, 0) < 6) begin
                k = $urandom_range(NST, 1);
                for (int j = 0; j < NST; j++) begin
                    int s; s = ((k - 1 + j) % NST) + 1;
                    if (!bv && busy[s] && s != ct) begin bv = 1; bt = s; end
                end
            end else if ($urandom_range(9, 0) == 0) begin
                bv = 1;
                bt = 0;
                for (int s = 1; s <= NST; s++) if (!busy[s] && s != ct) bt = s;
            end
            drive($urandom_range(NREG - 1, 0), $urandom_range(NREG - 1, 0),
                  cv, $urandom_range(NREG - 1, 0), ct, bv, bt, rnd64());
            step("");
        end
        summary();
    end
endmodule